// File: doc/BRIEF.md
# Read-Return Fan-Out Distributor

This block sits between the network side of a cluster and four processing cores and hands out read-return beats. Each beat arriving from the network carries a data word, a 2-bit core index for single-target delivery, and a 4-bit target mask with its own qualifier for multi-target delivery. The block picks the set of cores that should receive the beat. It presents the data to all four cores at once and holds the beat until every selected core has taken it.

The destination logic first turns the core index into a one-hot mask. From then on, single-target and multi-target beats follow one shared delivery path. Each core lane keeps a completion bit. A lane that is not selected marks itself complete as soon as the beat is loaded. A selected lane marks itself complete only when its core accepts. Only one beat is in flight at a time. The input handshake opens again only when all four lanes are complete.

Top module: `rdret_fanout`

## Requirements
- R1: After reset, `net_ready` is 1 and all four bits of `core_valid` are 0.
- R2: When a beat is loaded with `net_mask_vld`=1, bit i of `core_valid` rises on the next cycle exactly where bit i of `net_mask` is 1. `net_id` has no effect.
- R3: When a beat is loaded with `net_mask_vld`=0, only `core_valid[net_id]` rises on the next cycle. Index value k selects core k, and `net_mask` has no effect.
- R4: From the cycle after a load until the next load, every 32-bit slice of `core_data` equals the loaded data word and stays unchanged. Slice i is bits [32*i+31:32*i].
- R5: A raised `core_valid[i]` stays high while `core_ready[i]` is 0. It falls on the cycle after a cycle in which `core_ready[i]` is 1, so a core never takes the same beat twice.
- R6: A core that is not selected for a beat never sees `core_valid` high for that beat, whatever its `core_ready` does.
- R7: While any selected core has not yet accepted, `net_ready` is 0. It rises on the cycle after the last selected core accepts.
- R8: A beat loaded with `net_mask_vld`=1 and `net_mask`=0 delivers nothing, and `net_ready` is 1 on the very next cycle.
- R9: A new beat held on the input is loaded at the same clock edge where `net_ready` is 1, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| net_valid | input | 1 | Network offers a beat |
| net_ready | output | 1 | Block can take a beat |
| net_data | input | DATA_W | Beat payload |
| net_id | input | 2 | Single target core index |
| net_mask | input | 4 | Multi-target core mask, bit i = core i |
| net_mask_vld | input | 1 | Mask is in use and overrides the index |
| core_valid | output | 4 | Per-core beat valid |
| core_ready | input | 4 | Per-core accept |
| core_data | output | 4*DATA_W | Payload copied to each core, slice i for core i |

## Verification
The assertions assume that the network keeps to the handshake. A beat counts only when `net_valid` and `net_ready` are both high. The core index is always a legal value, because all four codes map to a core. Core readies may be high at any time, including for cores that are not selected. The stimulus raises `net_valid` only on cycles where it expects a load. It holds the readies of non-selected cores high during every beat, to show that they have no effect. It releases the selected cores one at a time, so that every partial-completion state is seen.

// File: rtl/rdret_pkg.sv
package rdret_pkg;
    localparam int CORE_CNT = 4;
    localparam int CORE_IDX_W = $clog2(CORE_CNT);

    typedef logic [CORE_CNT-1:0] core_mask_t;
    typedef logic [CORE_IDX_W-1:0] core_idx_t;
endpackage

// File: rtl/rdret_dest_sel.sv
module rdret_dest_sel
    import rdret_pkg::*;
(
    input  logic       mask_vld_i,
    input  core_mask_t mask_i,
    input  core_idx_t  idx_i,
    output core_mask_t dest_o
);
    core_mask_t idx_onehot;

    for (genvar g = 0; g < CORE_CNT; g++) begin : g_conv
        assign idx_onehot[g] = (idx_i == core_idx_t'(g));
    end

    // Explicit mask takes priority over the single index
    assign dest_o = mask_vld_i ? mask_i : idx_onehot;
endmodule

// File: rtl/rdret_lane.sv
module rdret_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic target_i,
    input  logic ready_i,
    output logic valid_o,
    output logic done_o
);
    logic done_d, done_q;

    always_comb begin
        done_d = done_q;
        if (load_i) begin
            done_d = !target_i;
        end else if (valid_o && ready_i) begin
            done_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else begin
            done_q <= done_d;
        end
    end

    assign valid_o = !done_q;
    assign done_o  = done_q;

    assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o);

    assert_valid_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && ready_i |=> !valid_o);

    assert_untargeted_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !target_i |=> !valid_o);
endmodule

// File: rtl/rdret_fanout.sv
module rdret_fanout
    import rdret_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       net_valid,
    output logic                       net_ready,
    input  logic [DATA_W-1:0]          net_data,
    input  logic [CORE_IDX_W-1:0]      net_id,
    input  logic [CORE_CNT-1:0]        net_mask,
    input  logic                       net_mask_vld,
    output logic [CORE_CNT-1:0]        core_valid,
    input  logic [CORE_CNT-1:0]        core_ready,
    output logic [CORE_CNT*DATA_W-1:0] core_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t      st_d, st_q;
    core_mask_t dest;
    core_mask_t lane_done;
    logic       load;

    rdret_dest_sel u_dest (
        .mask_vld_i (net_mask_vld),
        .mask_i     (net_mask),
        .idx_i      (net_id),
        .dest_o     (dest)
    );

    assign net_ready = &lane_done;
    assign load      = net_valid && net_ready;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = net_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < CORE_CNT; g++) begin : g_lane
        rdret_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .target_i (dest[g]),
            .ready_i  (core_ready[g]),
            .valid_o  (core_valid[g]),
            .done_o   (lane_done[g])
        );
        assign core_data[g*DATA_W +: DATA_W] = st_q.data;
    end

    assert_mask_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load && net_mask_vld |=> core_valid == $past(net_mask));

    assert_index_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load && !net_mask_vld |=> $onehot(core_valid));

    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_valid) |=> $stable(core_data));

    assert_empty_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load && net_mask_vld && (net_mask == '0) |=> net_ready);

    assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_valid) && ((core_valid & ~core_ready) != '0) |=> !net_ready);
endmodule

// File: tb/rdret_fanout_tb.sv
module rdret_fanout_tb_top;
    localparam int DW = 32;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          net_valid = 1'b0;
    logic          net_ready;
    logic [DW-1:0] net_data = '0;
    logic [1:0]    net_id = '0;
    logic [NC-1:0] net_mask = '0;
    logic          net_mask_vld = 1'b0;
    logic [NC-1:0] core_valid;
    logic [NC-1:0] core_ready = '0;
    logic [NC*DW-1:0] core_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rdret_fanout #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .net_ready(net_ready),
        .net_data(net_data), .net_id(net_id), .net_mask(net_mask),
        .net_mask_vld(net_mask_vld), .core_valid(core_valid),
        .core_ready(core_ready), .core_data(core_data)
    );

    // entry: {mask_vld, mask[3:0], id[1:0], data[31:0]}
    localparam int TN = 8;
    localparam logic [38:0] TBL [TN] = '{
        {1'b1, 4'b1111, 2'd0, 32'hA5A5_0001},
        {1'b1, 4'b0101, 2'd3, 32'h1234_5678},
        {1'b1, 4'b1000, 2'd0, 32'hDEAD_BEEF},
        {1'b0, 4'b1111, 2'd2, 32'h0F0F_F0F0},
        {1'b0, 4'b0000, 2'd0, 32'h0000_0001},
        {1'b0, 4'b0110, 2'd3, 32'hFFFF_FFFF},
        {1'b1, 4'b0010, 2'd2, 32'h8000_0000},
        {1'b1, 4'b1011, 2'd1, 32'h5555_AAAA}
    };

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_data(input logic [DW-1:0] exp, input string tag);
        for (int i = 0; i < NC; i++) chk(64'(core_data[i*DW +: DW]), 64'(exp), tag);
    endtask

    function automatic logic [NC-1:0] want(input logic vv, input logic [NC-1:0] m, input logic [1:0] id);
        return vv ? m : (4'b0001 << id);
    endfunction

    task automatic run_beat(input logic vv, input logic [NC-1:0] m, input logic [1:0] id,
                            input logic [DW-1:0] d);
        logic [NC-1:0] exp;
        logic [NC-1:0] left;
        string sel;
        exp = want(vv, m, id);
        sel = vv ? "R2" : "R3";
        @(negedge clk);
        net_valid = 1'b1; net_mask_vld = vv; net_mask = m; net_id = id; net_data = d;
        core_ready = ~exp;
        chk(64'(net_ready), 64'd1, "R7 idle ready");
        @(negedge clk);
        net_valid = 1'b0;
        chk(64'(core_valid), 64'(exp), sel);
        chk(64'(core_valid & ~exp), 64'd0, "R6");
        chk_data(d, "R4");
        @(negedge clk);
        chk(64'(core_valid), 64'(exp), "R5 hold");
        chk(64'(net_ready), 64'd0, "R7 busy");
        left = exp;
        for (int p = 0; p < NC; p++) begin
            if (exp[p]) begin
                core_ready = ~exp | (4'b0001 << p);
                @(negedge clk);
                left[p] = 1'b0;
                chk(64'(core_valid), 64'(left), "R5 drop");
                chk(64'(net_ready), 64'(left == '0), "R7");
                chk_data(d, "R4 stable");
            end
        end
        core_ready = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(64'(net_ready), 64'd1, "R1 ready in reset");
        chk(64'(core_valid), 64'd0, "R1 valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(64'(net_ready), 64'd1, "R1 ready");
        chk(64'(core_valid), 64'd0, "R1 valid");

        for (int t = 0; t < TN; t++) begin
            run_beat(TBL[t][38], TBL[t][37:34], TBL[t][33:32], TBL[t][31:0]);
        end

        // R8: valid but empty mask completes at once
        @(negedge clk);
        core_ready = '0;
        net_valid = 1'b1; net_mask_vld = 1'b1; net_mask = 4'b0000; net_id = 2'd1;
        net_data = 32'hCAFE_0000;
        @(negedge clk);
        net_valid = 1'b0;
        chk(64'(core_valid), 64'd0, "R8 nothing delivered");
        chk(64'(net_ready), 64'd1, "R8 ready again");

        // R9: back-to-back beats, all cores always ready
        @(negedge clk);
        core_ready = 4'b1111;
        net_valid = 1'b1; net_mask_vld = 1'b1; net_mask = 4'b1111; net_data = 32'h1111_1111;
        @(negedge clk);
        net_data = 32'h2222_2222; net_mask = 4'b0110;
        chk(64'(core_valid), 64'hF, "R9 first beat");
        chk_data(32'h1111_1111, "R9 first data");
        chk(64'(net_ready), 64'd0, "R7 busy b2b");
        @(negedge clk);
        chk(64'(net_ready), 64'd1, "R9 ready after accept");
        @(negedge clk);
        net_valid = 1'b0;
        chk(64'(core_valid), 64'h6, "R9 second beat");
        chk_data(32'h2222_2222, "R9 second data");
        @(negedge clk);
        chk(64'(core_valid), 64'd0, "R5 no repeat");
        core_ready = '0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule